// File: doc/BRIEF.md
# Partially Banked Shadow Register File

This block is the general-purpose register storage of a RISC-V style core. It can hold several alternate register contexts so that an interrupt handler can run on its own registers without spilling them to memory first. The integer file has 32 entries, `x0` to `x31`. Only the upper sixteen entries, `x16` to `x31`, get a separate copy for each context. The lower sixteen entries live in one common bank that every context reads and writes alike. The pointer registers `x2` to `x4` are in that common bank, so every context sees the same pointer values. An optional floating-point file of 32 entries, `f0` to `f31`, is copied in full for each context.

The parameter `NUM_SETS` gives the number of shadow contexts. The value 0 turns the feature off and leaves a plain 32-entry file. The parameter `FP_EN` turns the floating-point file on or off. An interrupt controller outside this block drives `set_sel` to pick a context, where 0 is the normal context. The chosen value is captured into an internal active-set register at the next clock edge. Every banked access uses that register. Software must still save and restore `x1` to `x15` around a handler. Switching contexts replaces the save and restore of `x16` to `x31` and `f0` to `f31`.

Reads are combinational. There are two integer read ports, one integer write port, three floating-point read ports and one floating-point write port. A write is committed at the clock edge. A read of the address being written in the same cycle returns the new data.

Top module: `shadow_rf`

## Requirements
- R1: Integer register 0 reads as zero on both read ports in every context, and a write to it changes nothing and is not forwarded.
- R2: A write to integer registers 1–15 goes to the common bank, and a later read returns the written value whichever context is active.
- R3: A write to integer registers 16–31 changes only the copy that belongs to the active context, and the copies of the other contexts keep their values.
- R4: When `FP_EN` is 1, each context has its own copy of all 32 floating-point registers, and a write changes only the active context's copy.
- R5: A new `set_sel` value takes effect at the next rising clock edge. A write issued in the cycle in which `set_sel` changes goes to the context that was active before that edge. Reads in that cycle also use the old context.
- R6: A `set_sel` value above `NUM_SETS` is ignored, and the active context stays unchanged.
- R7: When a write and a read address match in the same cycle, the read port returns the write data. This applies to the integer file (except register 0) and to the floating-point file.
- R8: `rst_n` low clears every register of every bank at once and sets the active context to 0. The release of reset is synchronised to `clk`.
- R9: With `NUM_SETS` = 0, `set_sel` has no effect and the file behaves as a single 32-entry file. With `FP_EN` = 0, the floating-point read ports return zero and floating-point writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_sel | input | SEL_W = max(1, ceil(log2(NUM_SETS+1))) | Requested context, 0 = normal context |
| int_ra_addr | input | 5 | Integer read port A address |
| int_ra_data | output | XLEN | Integer read port A data |
| int_rb_addr | input | 5 | Integer read port B address |
| int_rb_data | output | XLEN | Integer read port B data |
| int_we | input | 1 | Integer write enable |
| int_waddr | input | 5 | Integer write address |
| int_wdata | input | XLEN | Integer write data |
| fp_ra_addr | input | 5 | Floating-point read port A address |
| fp_ra_data | output | FLEN | Floating-point read port A data |
| fp_rb_addr | input | 5 | Floating-point read port B address |
| fp_rb_data | output | FLEN | Floating-point read port B data |
| fp_rc_addr | input | 5 | Floating-point read port C address |
| fp_rc_data | output | FLEN | Floating-point read port C data |
| fp_we | input | 1 | Floating-point write enable |
| fp_waddr | input | 5 | Floating-point write address |
| fp_wdata | input | FLEN | Floating-point write data |

## Verification
The hardest case to reach from the ports is the cycle in which `set_sel` changes while a banked write is in flight. Only the order of that write against the capture of the active-set register decides which copy receives the data. The bench drives the select change and a write to `x25` in the same cycle, with a read of `x25` held on a port. It checks that the read in that cycle is forwarded from the old context, that the new context still holds its earlier value, and that the data shows up only after switching back. The bench also fills every integer and floating-point address with data that encodes the context and the address, in every context, before reading everything back. This exposes any common entry that was wrongly banked, or any banked entry that was wrongly shared.

// File: rtl/shadow_rf_pkg.sv
package shadow_rf_pkg;
  localparam int REG_AW = 5;
  localparam int HALF_N = 16;
  localparam int FULL_N = 32;

  function automatic int sel_width(input int n_sets);
    return (n_sets < 1) ? 1 : $clog2(n_sets + 1);
  endfunction
endpackage

// File: rtl/shadow_rf_rstsync.sv
module shadow_rf_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/shadow_rf_sel.sv
module shadow_rf_sel #(
  parameter int NUM_SETS = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] set_sel,
  output logic [SEL_W-1:0] act
);
  logic [SEL_W-1:0] act_q;
  logic [SEL_W-1:0] act_d;
  logic             act_en;
  logic             sel_ok;

  always_comb begin
    sel_ok = (int'(set_sel) <= NUM_SETS);
    act_d  = sel_ok ? set_sel : act_q;
    act_en = (act_d != act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/shadow_rf_int.sv
module shadow_rf_int
  import shadow_rf_pkg::*;
#(
  parameter int NB    = 3,
  parameter int SEL_W = 2,
  parameter int XLEN  = 32,
  parameter int NRD   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEL_W-1:0]           act,
  input  logic                       we,
  input  logic [REG_AW-1:0]          waddr,
  input  logic [XLEN-1:0]            wdata,
  input  logic [NRD-1:0][REG_AW-1:0] raddr,
  output logic [NRD-1:0][XLEN-1:0]   rdata
);
  logic [XLEN-1:0] com_q  [HALF_N];
  logic [XLEN-1:0] bank_q [NB][HALF_N];
  logic [HALF_N-1:0]         com_en;
  logic [NB-1:0][HALF_N-1:0] bank_en;

  // next-state: one-hot write enables per entry
  always_comb begin
    com_en  = '0;
    bank_en = '0;
    if (we && (waddr != '0)) begin
      if (!waddr[REG_AW-1]) begin
        com_en[waddr[REG_AW-2:0]] = 1'b1;
      end else begin
        for (int b = 0; b < NB; b++) begin
          if (int'(act) == b) bank_en[b][waddr[REG_AW-2:0]] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HALF_N; i++) com_q[i] <= '0;
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < HALF_N; i++) bank_q[b][i] <= '0;
    end else begin
      for (int i = 0; i < HALF_N; i++)
        if (com_en[i]) com_q[i] <= wdata;
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < HALF_N; i++)
          if (bank_en[b][i]) bank_q[b][i] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [XLEN-1:0] bank_word;
    logic [XLEN-1:0] rd_word;
    always_comb begin
      bank_word = '0;
      for (int b = 0; b < NB; b++) begin
        if (int'(act) == b) bank_word = bank_q[b][raddr[p][REG_AW-2:0]];
      end
      if (raddr[p] == '0) begin
        rd_word = '0;
      end else if (we && (waddr == raddr[p])) begin
        rd_word = wdata;
      end else if (raddr[p][REG_AW-1]) begin
        rd_word = bank_word;
      end else begin
        rd_word = com_q[raddr[p][REG_AW-2:0]];
      end
    end
    assign rdata[p] = rd_word;
  end
endmodule

// File: rtl/shadow_rf_fp.sv
module shadow_rf_fp
  import shadow_rf_pkg::*;
#(
  parameter int NB    = 3,
  parameter int SEL_W = 2,
  parameter int FLEN  = 32,
  parameter int NRD   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEL_W-1:0]           act,
  input  logic                       we,
  input  logic [REG_AW-1:0]          waddr,
  input  logic [FLEN-1:0]            wdata,
  input  logic [NRD-1:0][REG_AW-1:0] raddr,
  output logic [NRD-1:0][FLEN-1:0]   rdata
);
  logic [FLEN-1:0] bank_q [NB][FULL_N];
  logic [NB-1:0][FULL_N-1:0] bank_en;

  always_comb begin
    bank_en = '0;
    if (we) begin
      for (int b = 0; b < NB; b++) begin
        if (int'(act) == b) bank_en[b][waddr] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < FULL_N; i++) bank_q[b][i] <= '0;
    end else begin
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < FULL_N; i++)
          if (bank_en[b][i]) bank_q[b][i] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [FLEN-1:0] bank_word;
    logic [FLEN-1:0] rd_word;
    always_comb begin
      bank_word = '0;
      for (int b = 0; b < NB; b++) begin
        if (int'(act) == b) bank_word = bank_q[b][raddr[p]];
      end
      rd_word = (we && (waddr == raddr[p])) ? wdata : bank_word;
    end
    assign rdata[p] = rd_word;
  end
endmodule

// File: rtl/shadow_rf.sv
module shadow_rf
  import shadow_rf_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int FP_EN    = 1,
  parameter int XLEN     = 32,
  parameter int FLEN     = 32,
  localparam int SEL_W   = sel_width(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  set_sel,
  input  logic [REG_AW-1:0] int_ra_addr,
  output logic [XLEN-1:0]   int_ra_data,
  input  logic [REG_AW-1:0] int_rb_addr,
  output logic [XLEN-1:0]   int_rb_data,
  input  logic              int_we,
  input  logic [REG_AW-1:0] int_waddr,
  input  logic [XLEN-1:0]   int_wdata,
  input  logic [REG_AW-1:0] fp_ra_addr,
  output logic [FLEN-1:0]   fp_ra_data,
  input  logic [REG_AW-1:0] fp_rb_addr,
  output logic [FLEN-1:0]   fp_rb_data,
  input  logic [REG_AW-1:0] fp_rc_addr,
  output logic [FLEN-1:0]   fp_rc_data,
  input  logic              fp_we,
  input  logic [REG_AW-1:0] fp_waddr,
  input  logic [FLEN-1:0]   fp_wdata
);
  localparam int NB = NUM_SETS + 1;

  logic             rst_sync_n;
  logic [SEL_W-1:0] act_set;

  shadow_rf_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  shadow_rf_sel #(.NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_sel (set_sel),
    .act     (act_set)
  );

  logic [1:0][REG_AW-1:0] int_raddr;
  logic [1:0][XLEN-1:0]   int_rdata;
  assign int_raddr   = {int_rb_addr, int_ra_addr};
  assign int_ra_data = int_rdata[0];
  assign int_rb_data = int_rdata[1];

  shadow_rf_int #(.NB(NB), .SEL_W(SEL_W), .XLEN(XLEN), .NRD(2)) u_int (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .act   (act_set),
    .we    (int_we),
    .waddr (int_waddr),
    .wdata (int_wdata),
    .raddr (int_raddr),
    .rdata (int_rdata)
  );

  if (FP_EN != 0) begin : g_fp
    logic [2:0][REG_AW-1:0] fp_raddr;
    logic [2:0][FLEN-1:0]   fp_rdata;
    assign fp_raddr   = {fp_rc_addr, fp_rb_addr, fp_ra_addr};
    assign fp_ra_data = fp_rdata[0];
    assign fp_rb_data = fp_rdata[1];
    assign fp_rc_data = fp_rdata[2];

    shadow_rf_fp #(.NB(NB), .SEL_W(SEL_W), .FLEN(FLEN), .NRD(3)) u_fp (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .act   (act_set),
      .we    (fp_we),
      .waddr (fp_waddr),
      .wdata (fp_wdata),
      .raddr (fp_raddr),
      .rdata (fp_rdata)
    );
  end else begin : g_nofp
    logic unused_fp;
    assign unused_fp  = ^{fp_ra_addr, fp_rb_addr, fp_rc_addr, fp_we, fp_waddr, fp_wdata};
    assign fp_ra_data = '0;
    assign fp_rb_data = '0;
    assign fp_rc_data = '0;
  end
endmodule

// File: rtl/shadow_rf_chk.sv
module shadow_rf_chk #(
  parameter int NUM_SETS = 2,
  parameter int FP_EN    = 1,
  parameter int XLEN     = 32,
  parameter int FLEN     = 32,
  parameter int SEL_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] set_sel,
  input logic [SEL_W-1:0] act,
  input logic [4:0]       int_ra_addr,
  input logic [XLEN-1:0]  int_ra_data,
  input logic [4:0]       int_rb_addr,
  input logic [XLEN-1:0]  int_rb_data,
  input logic             int_we,
  input logic [4:0]       int_waddr,
  input logic [XLEN-1:0]  int_wdata,
  input logic [4:0]       fp_ra_addr,
  input logic [FLEN-1:0]  fp_ra_data,
  input logic             fp_we,
  input logic [4:0]       fp_waddr,
  input logic [FLEN-1:0]  fp_wdata
);
  // R1
  x0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_ra_addr == 5'd0) |-> (int_ra_data == '0)) and
    ((int_rb_addr == 5'd0) |-> (int_rb_data == '0)));

  // R7
  int_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_we && (int_waddr != 5'd0) && (int_waddr == int_ra_addr)) |-> (int_ra_data == int_wdata));

  // R2
  common_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(int_we) && ($past(int_waddr) != 5'd0) && !$past(int_waddr[4]) &&
     !int_we && (int_ra_addr == $past(int_waddr))) |-> (int_ra_data == $past(int_wdata)));

  // R4
  fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((FP_EN != 0) && $past(rst_n) && $past(fp_we) && $stable(act) && !fp_we &&
     (fp_ra_addr == $past(fp_waddr))) |-> (fp_ra_data == $past(fp_wdata)));

  // R5
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (int'($past(set_sel)) <= NUM_SETS)) |-> (act == $past(set_sel)));

  // R6
  sel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (int'($past(set_sel)) > NUM_SETS)) |-> $stable(act));

  // R8
  reset_set0_chk: assert property (@(posedge clk)
    !rst_n |-> (act == '0));
endmodule

bind shadow_rf shadow_rf_chk #(
  .NUM_SETS (NUM_SETS),
  .FP_EN    (FP_EN),
  .XLEN     (XLEN),
  .FLEN     (FLEN),
  .SEL_W    (SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .set_sel     (set_sel),
  .act         (act_set),
  .int_ra_addr (int_ra_addr),
  .int_ra_data (int_ra_data),
  .int_rb_addr (int_rb_addr),
  .int_rb_data (int_rb_data),
  .int_we      (int_we),
  .int_waddr   (int_waddr),
  .int_wdata   (int_wdata),
  .fp_ra_addr  (fp_ra_addr),
  .fp_ra_data  (fp_ra_data),
  .fp_we       (fp_we),
  .fp_waddr    (fp_waddr),
  .fp_wdata    (fp_wdata)
);

// File: tb/shadow_rf_bench.sv
`timescale 1ns/1ps
module shadow_rf_bench;
  localparam int NS = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [1:0]  set_sel;
  logic [4:0]  int_ra_addr, int_rb_addr, int_waddr;
  logic [31:0] int_ra_data, int_rb_data, int_wdata;
  logic        int_we;
  logic [4:0]  fp_ra_addr, fp_rb_addr, fp_rc_addr, fp_waddr;
  logic [31:0] fp_ra_data, fp_rb_data, fp_rc_data, fp_wdata;
  logic        fp_we;

  logic        p_sel;
  logic [4:0]  p_ra_addr, p_waddr;
  logic [31:0] p_ra_data, p_rb_data, p_wdata;
  logic        p_we;
  logic        p_fp_we;
  logic [31:0] p_fa_data, p_fb_data, p_fc_data;

  shadow_rf #(.NUM_SETS(NS), .FP_EN(1)) u_shadow_rf (
    .clk(clk), .rst_n(rst_n), .set_sel(set_sel),
    .int_ra_addr(int_ra_addr), .int_ra_data(int_ra_data),
    .int_rb_addr(int_rb_addr), .int_rb_data(int_rb_data),
    .int_we(int_we), .int_waddr(int_waddr), .int_wdata(int_wdata),
    .fp_ra_addr(fp_ra_addr), .fp_ra_data(fp_ra_data),
    .fp_rb_addr(fp_rb_addr), .fp_rb_data(fp_rb_data),
    .fp_rc_addr(fp_rc_addr), .fp_rc_data(fp_rc_data),
    .fp_we(fp_we), .fp_waddr(fp_waddr), .fp_wdata(fp_wdata)
  );

  shadow_rf #(.NUM_SETS(0), .FP_EN(0)) u_plain (
    .clk(clk), .rst_n(rst_n), .set_sel(p_sel),
    .int_ra_addr(p_ra_addr), .int_ra_data(p_ra_data),
    .int_rb_addr(5'd0), .int_rb_data(p_rb_data),
    .int_we(p_we), .int_waddr(p_waddr), .int_wdata(p_wdata),
    .fp_ra_addr(5'd3), .fp_ra_data(p_fa_data),
    .fp_rb_addr(5'd3), .fp_rb_data(p_fb_data),
    .fp_rc_addr(5'd4), .fp_rc_data(p_fc_data),
    .fp_we(p_fp_we), .fp_waddr(5'd3), .fp_wdata(32'hDEAD_0003)
  );

  int checks = 0;
  int errors = 0;
  int exp_act = 0;
  logic [31:0] exp_com  [16];
  logic [31:0] exp_bank [NS+1][16];
  logic [31:0] exp_fp   [NS+1][32];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, want);
    end
  endtask

  function automatic logic [31:0] exp_int(input int a);
    if (a == 0) return 32'd0;
    if (a < 16) return exp_com[a];
    return exp_bank[exp_act][a-16];
  endfunction

  function automatic string int_tag(input int a);
    if (a == 0) return "R1";
    if (a < 16) return "R2";
    return "R3";
  endfunction

  function automatic logic [31:0] pat(input int s, input int a, input int salt);
    return {8'(s), 8'(a), 8'(salt), 8'h5A} ^ 32'h0F0F_0000;
  endfunction

  task automatic clear_model();
    exp_act = 0;
    for (int i = 0; i < 16; i++) exp_com[i] = '0;
    for (int s = 0; s <= NS; s++) begin
      for (int i = 0; i < 16; i++) exp_bank[s][i] = '0;
      for (int i = 0; i < 32; i++) exp_fp[s][i] = '0;
    end
  endtask

  task automatic wr_int(input int a, input logic [31:0] d);
    @(negedge clk);
    int_we = 1'b1; int_waddr = 5'(a); int_wdata = d;
    @(negedge clk);
    int_we = 1'b0;
    if (a != 0 && a < 16) exp_com[a] = d;
    else if (a >= 16) exp_bank[exp_act][a-16] = d;
  endtask

  task automatic wr_fp(input int a, input logic [31:0] d);
    @(negedge clk);
    fp_we = 1'b1; fp_waddr = 5'(a); fp_wdata = d;
    @(negedge clk);
    fp_we = 1'b0;
    exp_fp[exp_act][a] = d;
  endtask

  task automatic select(input int s);
    @(negedge clk);
    set_sel = 2'(s);
    @(negedge clk);
    if (s <= NS) exp_act = s;
  endtask

  task automatic rd_int(input int a, input int b, input string tag);
    @(negedge clk);
    int_ra_addr = 5'(a); int_rb_addr = 5'(b);
    #1;
    chk((tag == "") ? int_tag(a) : tag, int_ra_data, exp_int(a));
    chk((tag == "") ? int_tag(b) : tag, int_rb_data, exp_int(b));
  endtask

  task automatic rd_fp(input int a, input string tag);
    @(negedge clk);
    fp_ra_addr = 5'(a); fp_rb_addr = 5'((a + 11) % 32); fp_rc_addr = 5'((a + 23) % 32);
    #1;
    chk(tag, fp_ra_data, exp_fp[exp_act][a]);
    chk(tag, fp_rb_data, exp_fp[exp_act][(a + 11) % 32]);
    chk(tag, fp_rc_data, exp_fp[exp_act][(a + 23) % 32]);
  endtask

  task automatic sweep_all(input string itag, input string ftag);
    for (int s = 0; s <= NS; s++) begin
      select(s);
      for (int a = 0; a < 32; a++) rd_int(a, 31 - a, itag);
      for (int a = 0; a < 32; a++) rd_fp(a, ftag);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; set_sel = '0;
    int_ra_addr = '0; int_rb_addr = '0; int_we = 1'b0; int_waddr = '0; int_wdata = '0;
    fp_ra_addr = '0; fp_rb_addr = '0; fp_rc_addr = '0; fp_we = 1'b0; fp_waddr = '0; fp_wdata = '0;
    p_sel = 1'b0; p_ra_addr = '0; p_we = 1'b0; p_waddr = '0; p_wdata = '0; p_fp_we = 1'b0;
    clear_model();
    repeat (4) @(negedge clk);
    // R8: contents read zero while reset is held
    int_ra_addr = 5'd20; int_rb_addr = 5'd7; fp_ra_addr = 5'd9;
    #1;
    chk("R8", int_ra_data, 32'd0);
    chk("R8", int_rb_data, 32'd0);
    chk("R8", fp_ra_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 32; a++) rd_int(a, 31 - a, "R8");

    // R1 R2 R3 R4: fill every address in every context, then read all back
    for (int s = 0; s <= NS; s++) begin
      select(s);
      for (int a = 0; a < 32; a++) wr_int(a, pat(s, a, 1));
      for (int a = 0; a < 32; a++) wr_fp(a, pat(s, a, 2));
    end
    sweep_all("", "R4");

    // R2: common write from a shadow context seen from context 0
    select(2);
    wr_int(3, 32'h1234_5678);
    select(0);
    rd_int(3, 4, "R2");

    // R7: same-cycle forwarding on integer and fp ports
    select(1);
    @(negedge clk);
    int_we = 1'b1; int_waddr = 5'd20; int_wdata = 32'hA0A0_2020;
    int_ra_addr = 5'd20; int_rb_addr = 5'd20;
    fp_we = 1'b1; fp_waddr = 5'd7; fp_wdata = 32'hF7F7_0707;
    fp_ra_addr = 5'd7; fp_rb_addr = 5'd7; fp_rc_addr = 5'd8;
    #1;
    chk("R7", int_ra_data, 32'hA0A0_2020);
    chk("R7", int_rb_data, 32'hA0A0_2020);
    chk("R7", fp_ra_data, 32'hF7F7_0707);
    chk("R7", fp_rb_data, 32'hF7F7_0707);
    chk("R7", fp_rc_data, exp_fp[1][8]);
    @(negedge clk);
    int_we = 1'b0; fp_we = 1'b0;
    exp_bank[1][4] = 32'hA0A0_2020;
    exp_fp[1][7] = 32'hF7F7_0707;
    rd_int(20, 5, "R7");
    rd_fp(7, "R7");
    // R1: write to x0 with a read of x0 in the same cycle
    @(negedge clk);
    int_we = 1'b1; int_waddr = 5'd0; int_wdata = 32'hFFFF_FFFF;
    int_ra_addr = 5'd0; int_rb_addr = 5'd0;
    #1;
    chk("R1", int_ra_data, 32'd0);
    chk("R1", int_rb_data, 32'd0);
    @(negedge clk);
    int_we = 1'b0;
    rd_int(0, 0, "R1");

    // R5: write in the same cycle as a select change
    @(negedge clk);
    set_sel = 2'd2;
    int_we = 1'b1; int_waddr = 5'd25; int_wdata = 32'h5555_0025;
    int_ra_addr = 5'd25; int_rb_addr = 5'd26;
    #1;
    chk("R5", int_ra_data, 32'h5555_0025);
    chk("R5", int_rb_data, exp_bank[1][10]);
    @(negedge clk);
    int_we = 1'b0;
    exp_bank[1][9] = 32'h5555_0025;
    exp_act = 2;
    #1;
    chk("R5", int_ra_data, exp_bank[2][9]);
    @(negedge clk);
    set_sel = 2'd1;
    #1;
    chk("R5", int_ra_data, exp_bank[2][9]);
    @(negedge clk);
    exp_act = 1;
    #1;
    chk("R5", int_ra_data, 32'h5555_0025);

    // R6: out-of-range select leaves context unchanged
    select(3);
    for (int a = 16; a < 32; a++) rd_int(a, 47 - a, "R6");
    rd_fp(5, "R6");
    select(0);
    select(3);
    for (int a = 16; a < 32; a++) rd_int(a, 47 - a, "R6");

    // R9: plain configuration
    @(negedge clk);
    p_we = 1'b1; p_waddr = 5'd20; p_wdata = 32'hC0DE_0020; p_fp_we = 1'b1;
    @(negedge clk);
    p_we = 1'b0; p_fp_we = 1'b0; p_sel = 1'b1;
    @(negedge clk);
    @(negedge clk);
    p_ra_addr = 5'd20;
    #1;
    chk("R9", p_ra_data, 32'hC0DE_0020);
    chk("R9", p_rb_data, 32'd0);
    chk("R9", p_fa_data, 32'd0);
    chk("R9", p_fc_data, 32'd0);
    @(negedge clk);
    p_we = 1'b1; p_waddr = 5'd21; p_wdata = 32'hC0DE_0021; p_sel = 1'b0;
    @(negedge clk);
    p_we = 1'b0;
    @(negedge clk);
    p_ra_addr = 5'd21;
    #1;
    chk("R9", p_ra_data, 32'hC0DE_0021);
    p_ra_addr = 5'd20;
    #1;
    chk("R9", p_ra_data, 32'hC0DE_0020);

    // R8: reset in the middle of operation clears every bank
    select(0);
    @(negedge clk);
    rst_n = 1'b0;
    int_ra_addr = 5'd3; fp_ra_addr = 5'd7;
    #1;
    chk("R8", int_ra_data, 32'd0);
    chk("R8", fp_ra_data, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    repeat (4) @(negedge clk);
    sweep_all("R8", "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule